// File: doc/BRIEF.md
# Shared Memory Bus Slot Scheduler

This block divides a shared memory bus into slots and decides, one slot per clock, which agent owns each slot: the CPU, the text display, the sprite engine or DRAM refresh. A scan line holds 126 slots. The first 80 slots go to the text screen in groups of four. The next 40 slots go to eight sprite groups, each with four fetch slots and one spare slot. The last six slots hold four refresh cycles and two spare slots. Spare slots and any slot that no agent claims are given to the CPU, and a ready output tells the CPU it may use the current slot.

Character codes for a new text row are fetched over two lines rather than one. The last pixel line of a row and the first pixel line of the next row each take one character fetch per four-slot group. Each group also keeps one slot free, so text fetching never holds the CPU off for more than three slots in a row. On the other text lines only the two shape fetches of each group are made.

The CPU can start a refresh burst by writing to one fixed address in a slot it owns. The burst takes the next four CPU-available slots. It replaces the normal refresh of the current line, or of the next line if the current line's refresh has already started. Software that keeps triggering bursts while the screen is blanked can therefore control exactly where the bus is taken from it.

Top module: `membus_slot_sched`

## Requirements
- R1: The slot number counts 0 to 125 and then returns to 0, advancing the line number, which counts 0 to 311 and then returns to 0. A synchronous active-low reset puts both at 0.
- R2: Slot map of every line. Slots 0-79 are text slots. Slots 80-119 form eight five-slot sprite groups: sprite fetch in group positions 0-3 and CPU in position 4. Slots 120-123 are refresh and slots 124-125 are CPU.
- R3: Encodings. owner is 0 for CPU, 1 for text, 2 for sprite and 3 for refresh. fetch_kind is 0 for no fetch, 1 for character and 2 for shape. fetch_right is 1 for a right-half fetch. cpu_rdy is 1 exactly when owner is CPU. Sprite and refresh slots report fetch_kind 0 and fetch_right 0.
- R4: On a displayed line whose row phase (line mod 8) is 1 to 6, each text group, at positions slot mod 4 = 0,1,2,3, is: left shape, CPU, right shape, CPU.
- R5: On a displayed line with row phase 7, each text group is: left shape, left character, right shape, CPU.
- R6: On a displayed line with row phase 0, each text group is: left shape, right character, right shape, CPU.
- R7: A line is displayed when line < 200 and disp_en is 1. On any other line the text and sprite slots all go to the CPU, and refresh slots 120-123 still run.
- R8: A write (cpu_wr=1) to address 0xFF3C in a slot where cpu_rdy is 1 claims the next four CPU-available slots as refresh slots. Text and sprite fetches keep their slots.
- R9: If that write is made in a slot below 120, the normal refresh slots 120-123 of the same line become CPU slots.
- R10: If that write is made in slot 120 or later, the current line keeps its normal refresh, and slots 120-123 of the following line become CPU slots.
- R11: A write to any other address, or a write made in a slot where cpu_rdy is 0, has no effect on the schedule.
- R12: When no forced refresh is in progress, cpu_rdy is never low for more than five slots in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| disp_en | input | 1 | Screen enable; 0 blanks text and sprite fetches |
| cpu_wr | input | 1 | CPU write strobe for the current slot |
| cpu_addr | input | 16 | CPU address for the current slot |
| slot_num | output | 7 | Current slot within the line |
| line_num | output | 9 | Current scan line within the frame |
| owner | output | 2 | Slot owner code |
| fetch_kind | output | 2 | Text fetch type for the slot |
| fetch_right | output | 1 | Fetch targets the right half of the cell pair |
| cpu_rdy | output | 1 | CPU may use this slot |

## Verification
The bench checks that the two half-bad lines are told apart, because a design that swapped them would fetch the right character first and report the wrong half. It triggers forced refresh on both sides of slot 120 and across the end of a line, where a design that chose the wrong line to suppress would drop a refresh or leave an extra one in place. Forced refresh on a half-bad line has to skip over the text fetch slots; a design that took the next four slots in a row would steal character fetches. Stray writes to another address or in an owned slot must leave the schedule unchanged, and the longest CPU stall must be exactly four slots.

// File: rtl/membus_sched_pkg.sv
// Package: shared types for the bus slot scheduler.
// Assumes: owner and fetch codes are the externally visible encodings.
package membus_sched_pkg;

    typedef enum logic [1:0] {
        OWN_CPU     = 2'd0,
        OWN_TEXT    = 2'd1,
        OWN_SPRITE  = 2'd2,
        OWN_REFRESH = 2'd3
    } owner_e;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_CHAR  = 2'd1,
        FK_SHAPE = 2'd2
    } fkind_e;

    typedef enum logic [1:0] {
        LC_BLANK  = 2'd0,
        LC_PLAIN  = 2'd1,
        LC_HALF_A = 2'd2,
        LC_HALF_B = 2'd3
    } lclass_e;

endpackage

// File: rtl/msched_timer.sv
// Module: slot and line counters for the bus schedule.
// Assumes: one slot per clock; the line counter advances on the last slot.
module msched_timer #(
    parameter int LINE_SLOTS  = 126,
    parameter int FRAME_LINES = 312,
    localparam int SLOT_W = $clog2(LINE_SLOTS),
    localparam int LINE_W = $clog2(FRAME_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot,
    output logic [LINE_W-1:0] line,
    output logic              line_end
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LINE_SLOTS - 1);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(FRAME_LINES - 1);

    assign line_end = (slot == LAST_SLOT);

    // Slot counter: wraps at the end of each line.
    always_ff @(posedge clk) begin
        if (!rst_n)        slot <= '0;
        else if (line_end) slot <= '0;
        else               slot <= slot + 1'b1;
    end

    // Line counter: advances once per line, wraps at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                 line <= '0;
        else if (line_end) begin
            if (line == LAST_LINE)  line <= '0;
            else                    line <= line + 1'b1;
        end
    end

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (slot == '0)); // R1

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && line != LAST_LINE) |=> (line == $past(line) + 1'b1)); // R1

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(line)); // R1

endmodule

// File: rtl/msched_line_class.sv
// Module: classifies the current line as blank, plain text or half-bad.
// Assumes: ROW_LINES is a power of two; rows start at line 0.
module msched_line_class
    import membus_sched_pkg::*;
#(
    parameter int FRAME_LINES  = 312,
    parameter int ACTIVE_LINES = 200,
    parameter int ROW_LINES    = 8,
    localparam int LINE_W = $clog2(FRAME_LINES),
    localparam int ROW_W  = $clog2(ROW_LINES)
) (
    input  logic [LINE_W-1:0] line,
    input  logic              disp_en,
    output lclass_e           lclass
);

    localparam logic [ROW_W-1:0] PH_LAST = ROW_W'(ROW_LINES - 1);

    logic [ROW_W-1:0] phase;
    assign phase = line[ROW_W-1:0];

    // Pick the line class from the display window and row phase.
    always_comb begin
        if (!disp_en || line >= LINE_W'(ACTIVE_LINES)) lclass = LC_BLANK;
        else if (phase == PH_LAST)                     lclass = LC_HALF_A;
        else if (phase == '0)                          lclass = LC_HALF_B;
        else                                           lclass = LC_PLAIN;
    end

endmodule

// File: rtl/msched_pattern.sv
// Module: fixed slot map of one line, before any forced refresh is applied.
// Assumes: text groups are four slots wide and start at slot 0.
module msched_pattern
    import membus_sched_pkg::*;
#(
    parameter int TEXT_GROUPS = 20,
    parameter int SPR_GROUPS  = 8,
    parameter int SPR_ACTIVE  = 4,
    parameter int REF_DMA     = 4,
    parameter int REF_IDLE    = 2,
    localparam int TEXT_END   = 4 * TEXT_GROUPS,
    localparam int SPR_GRP    = SPR_ACTIVE + 1,
    localparam int SPR_END    = TEXT_END + SPR_GROUPS * SPR_GRP,
    localparam int REF_END    = SPR_END + REF_DMA,
    localparam int LINE_SLOTS = REF_END + REF_IDLE,
    localparam int SLOT_W     = $clog2(LINE_SLOTS)
) (
    input  logic [SLOT_W-1:0] slot,
    input  lclass_e           lclass,
    output owner_e            own,
    output fkind_e            kind,
    output logic              right,
    output logic              norm_ref
);

    logic [SLOT_W-1:0] spr_off;
    logic [SLOT_W-1:0] spr_pos;

    assign spr_off = slot - SLOT_W'(TEXT_END);
    assign spr_pos = spr_off % SLOT_W'(SPR_GRP);

    // Decode owner and fetch type from slot position and line class.
    always_comb begin
        own      = OWN_CPU;
        kind     = FK_NONE;
        right    = 1'b0;
        norm_ref = 1'b0;
        if (slot < SLOT_W'(TEXT_END)) begin
            if (lclass != LC_BLANK) begin
                case (slot[1:0])
                    2'd0: begin
                        own  = OWN_TEXT;
                        kind = FK_SHAPE;
                    end
                    2'd1: begin
                        if (lclass == LC_HALF_A) begin
                            own  = OWN_TEXT;
                            kind = FK_CHAR;
                        end else if (lclass == LC_HALF_B) begin
                            own   = OWN_TEXT;
                            kind  = FK_CHAR;
                            right = 1'b1;
                        end
                    end
                    2'd2: begin
                        own   = OWN_TEXT;
                        kind  = FK_SHAPE;
                        right = 1'b1;
                    end
                    default: own = OWN_CPU;
                endcase
            end
        end else if (slot < SLOT_W'(SPR_END)) begin
            if (lclass != LC_BLANK && spr_pos < SLOT_W'(SPR_ACTIVE))
                own = OWN_SPRITE;
        end else if (slot < SLOT_W'(REF_END)) begin
            own      = OWN_REFRESH;
            norm_ref = 1'b1;
        end
    end

endmodule

// File: rtl/msched_refresh.sv
// Module: forced-refresh burst counter and per-line refresh suppression.
// Assumes: trig only occurs in a CPU-owned slot, so never while a burst is pending.
module msched_refresh #(
    parameter int LINE_SLOTS = 126,
    parameter int REF_START  = 120,
    parameter int FORCE_CNT  = 4,
    localparam int SLOT_W = $clog2(LINE_SLOTS),
    localparam int CNT_W  = $clog2(FORCE_CNT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot,
    input  logic              line_end,
    input  logic              trig,
    input  logic              take,
    output logic              sup_cur,
    output logic              frc_pend
);

    logic [CNT_W-1:0] frc_left;
    logic             sup_next;
    logic             late;
    logic             early;

    assign frc_pend = (frc_left != '0);
    assign late     = trig && (slot >= SLOT_W'(REF_START));
    assign early    = trig && (slot <  SLOT_W'(REF_START));

    // Burst counter: load on trigger, count down per claimed free slot.
    always_ff @(posedge clk) begin
        if (!rst_n)    frc_left <= '0;
        else if (trig) frc_left <= CNT_W'(FORCE_CNT);
        else if (take) frc_left <= frc_left - 1'b1;
    end

    // Suppression flags: current line for early triggers, next line for late ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sup_cur  <= 1'b0;
            sup_next <= 1'b0;
        end else if (line_end) begin
            sup_cur  <= sup_next | late;
            sup_next <= 1'b0;
        end else begin
            if (early) sup_cur  <= 1'b1;
            if (late)  sup_next <= 1'b1;
        end
    end

    AST_FORCE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (frc_left == CNT_W'(FORCE_CNT))); // R8

    AST_FORCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !take) |=> $stable(frc_left)); // R8

    AST_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
        frc_pend |-> !trig); // R11

    AST_SUP_NEXT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (late && line_end) |=> sup_cur); // R10

endmodule

// File: rtl/membus_slot_sched.sv
// Module: top of the shared memory bus slot scheduler.
// Assumes: one slot per clock; cpu_wr/cpu_addr are valid for the current slot.
module membus_slot_sched
    import membus_sched_pkg::*;
#(
    parameter int TEXT_GROUPS  = 20,
    parameter int SPR_GROUPS   = 8,
    parameter int SPR_ACTIVE   = 4,
    parameter int REF_DMA      = 4,
    parameter int REF_IDLE     = 2,
    parameter int FRAME_LINES  = 312,
    parameter int ACTIVE_LINES = 200,
    parameter int ROW_LINES    = 8,
    parameter int ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] FORCE_ADDR = 16'hFF3C,
    parameter int MAX_STALL    = 5,
    localparam int TEXT_END    = 4 * TEXT_GROUPS,
    localparam int SPR_END     = TEXT_END + SPR_GROUPS * (SPR_ACTIVE + 1),
    localparam int LINE_SLOTS  = SPR_END + REF_DMA + REF_IDLE,
    localparam int SLOT_W      = $clog2(LINE_SLOTS),
    localparam int LINE_W      = $clog2(FRAME_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_en,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [SLOT_W-1:0] slot_num,
    output logic [LINE_W-1:0] line_num,
    output logic [1:0]        owner,
    output logic [1:0]        fetch_kind,
    output logic              fetch_right,
    output logic              cpu_rdy
);

    logic    line_end;
    lclass_e lclass;
    owner_e  base_own;
    fkind_e  base_kind;
    logic    base_right;
    logic    norm_ref;
    logic    sup_cur;
    logic    frc_pend;
    logic    free_slot;
    logic    take;
    logic    trig;
    owner_e  own_q;

    msched_timer #(
        .LINE_SLOTS (LINE_SLOTS),
        .FRAME_LINES(FRAME_LINES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot    (slot_num),
        .line    (line_num),
        .line_end(line_end)
    );

    msched_line_class #(
        .FRAME_LINES (FRAME_LINES),
        .ACTIVE_LINES(ACTIVE_LINES),
        .ROW_LINES   (ROW_LINES)
    ) u_class (
        .line   (line_num),
        .disp_en(disp_en),
        .lclass (lclass)
    );

    msched_pattern #(
        .TEXT_GROUPS(TEXT_GROUPS),
        .SPR_GROUPS (SPR_GROUPS),
        .SPR_ACTIVE (SPR_ACTIVE),
        .REF_DMA    (REF_DMA),
        .REF_IDLE   (REF_IDLE)
    ) u_pattern (
        .slot    (slot_num),
        .lclass  (lclass),
        .own     (base_own),
        .kind    (base_kind),
        .right   (base_right),
        .norm_ref(norm_ref)
    );

    msched_refresh #(
        .LINE_SLOTS(LINE_SLOTS),
        .REF_START (SPR_END),
        .FORCE_CNT (REF_DMA)
    ) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot    (slot_num),
        .line_end(line_end),
        .trig    (trig),
        .take    (take),
        .sup_cur (sup_cur),
        .frc_pend(frc_pend)
    );

    // A slot is free when the map gives it to the CPU or its refresh is suppressed.
    assign free_slot = (base_own == OWN_CPU) || (norm_ref && sup_cur);
    assign take      = free_slot && frc_pend;

    // Final owner: forced refresh first, then suppression, then the fixed map.
    always_comb begin
        if (take)           own_q = OWN_REFRESH;
        else if (free_slot) own_q = OWN_CPU;
        else                own_q = base_own;
    end

    assign owner       = own_q;
    assign fetch_kind  = (own_q == OWN_TEXT) ? base_kind  : FK_NONE;
    assign fetch_right = (own_q == OWN_TEXT) ? base_right : 1'b0;
    assign cpu_rdy     = (own_q == OWN_CPU);
    assign trig        = cpu_rdy && cpu_wr && (cpu_addr == FORCE_ADDR);

    // Stall tracking for the stall-bound check: run length and forced-slot flag.
    logic [2:0] stall_run;
    logic       frc_seen;
    always_ff @(posedge clk) begin
        if (!rst_n || cpu_rdy) begin
            stall_run <= '0;
            frc_seen  <= 1'b0;
        end else begin
            if (stall_run != 3'd7) stall_run <= stall_run + 1'b1;
            frc_seen <= frc_seen | take;
        end
    end

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rdy && !take && !frc_seen) |-> (stall_run < 3'(MAX_STALL))); // R12

    AST_NORMAL_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_num >= SLOT_W'(SPR_END) && slot_num < SLOT_W'(SPR_END + REF_DMA) && !sup_cur)
        |-> (owner == OWN_REFRESH)); // R2

    AST_TEXT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (base_own == OWN_TEXT) |-> (owner == OWN_TEXT)); // R8

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_kind != 2'd3)); // R3

endmodule

// File: tb/sim_membus_slot_sched.sv
module sim_membus_slot_sched;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] FADDR = 16'hFF3C;
    localparam int NV = 26;

    // {line[9], slot[7], owner[2], kind[2], right[1], rdy[1], req[4]}
    localparam logic [25:0] VEC [0:NV-1] = '{
        {9'd7,   7'd0,   2'd1, 2'd2, 1'b0, 1'b0, 4'd5},  // R5 left shape
        {9'd7,   7'd1,   2'd1, 2'd1, 1'b0, 1'b0, 4'd5},  // R5 left char
        {9'd7,   7'd2,   2'd1, 2'd2, 1'b1, 1'b0, 4'd5},  // R5 right shape
        {9'd7,   7'd3,   2'd0, 2'd0, 1'b0, 1'b1, 4'd5},  // R5 free
        {9'd7,   7'd77,  2'd1, 2'd1, 1'b0, 1'b0, 4'd5},  // R5 last group char
        {9'd7,   7'd79,  2'd0, 2'd0, 1'b0, 1'b1, 4'd5},  // R5
        {9'd8,   7'd1,   2'd1, 2'd1, 1'b1, 1'b0, 4'd6},  // R6 right char
        {9'd8,   7'd2,   2'd1, 2'd2, 1'b1, 1'b0, 4'd6},  // R6
        {9'd8,   7'd3,   2'd0, 2'd0, 1'b0, 1'b1, 4'd6},  // R6
        {9'd9,   7'd0,   2'd1, 2'd2, 1'b0, 1'b0, 4'd4},  // R4
        {9'd9,   7'd1,   2'd0, 2'd0, 1'b0, 1'b1, 4'd4},  // R4
        {9'd9,   7'd2,   2'd1, 2'd2, 1'b1, 1'b0, 4'd4},  // R4
        {9'd9,   7'd3,   2'd0, 2'd0, 1'b0, 1'b1, 4'd4},  // R4
        {9'd9,   7'd80,  2'd2, 2'd0, 1'b0, 1'b0, 4'd2},  // R2 sprite
        {9'd9,   7'd83,  2'd2, 2'd0, 1'b0, 1'b0, 4'd2},  // R2
        {9'd9,   7'd84,  2'd0, 2'd0, 1'b0, 1'b1, 4'd2},  // R2 sprite idle
        {9'd9,   7'd118, 2'd2, 2'd0, 1'b0, 1'b0, 4'd2},  // R2
        {9'd9,   7'd119, 2'd0, 2'd0, 1'b0, 1'b1, 4'd2},  // R2
        {9'd9,   7'd120, 2'd3, 2'd0, 1'b0, 1'b0, 4'd2},  // R2 refresh
        {9'd9,   7'd123, 2'd3, 2'd0, 1'b0, 1'b0, 4'd2},  // R2
        {9'd9,   7'd124, 2'd0, 2'd0, 1'b0, 1'b1, 4'd3},  // R3 idle is ready
        {9'd9,   7'd125, 2'd0, 2'd0, 1'b0, 1'b1, 4'd3},  // R3
        {9'd199, 7'd1,   2'd1, 2'd1, 1'b0, 1'b0, 4'd5},  // R5 last active row
        {9'd200, 7'd0,   2'd0, 2'd0, 1'b0, 1'b1, 4'd7},  // R7 blank line
        {9'd250, 7'd81,  2'd0, 2'd0, 1'b0, 1'b1, 4'd7},  // R7
        {9'd250, 7'd120, 2'd3, 2'd0, 1'b0, 1'b0, 4'd7}   // R7 refresh in blank
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_en = 1'b1;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [6:0]  slot_num;
    logic [8:0]  line_num;
    logic [1:0]  owner;
    logic [1:0]  fetch_kind;
    logic        fetch_right;
    logic        cpu_rdy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int run_len = 0;
    int max_run = 0;
    logic mon_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    membus_slot_sched u0 (
        .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .slot_num(slot_num), .line_num(line_num),
        .owner(owner), .fetch_kind(fetch_kind), .fetch_right(fetch_right),
        .cpu_rdy(cpu_rdy)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at line %0d slot %0d: actual %0d expected %0d",
                     req, what, line_num, slot_num, act, exp);
        end
    endtask

    task automatic wait_to(input int l, input int s);
        while (!(int'(line_num) == l && int'(slot_num) == s)) @(negedge clk);
    endtask

    task automatic chk_slot(input string req, input int own, input int rdy);
        check_eq(req, "owner", int'(owner), own);
        check_eq(req, "cpu_rdy", int'(cpu_rdy), rdy);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog and stall monitor.
    always @(negedge clk) begin
        cyc++;
        if (mon_en) begin
            run_len = cpu_rdy ? 0 : run_len + 1;
            if (run_len > max_run) max_run = run_len;
        end
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_eq("R1", "slot_num", int'(slot_num), 0);
        check_eq("R1", "line_num", int'(line_num), 0);
        check_eq("R3", "owner", int'(owner), 1);
        check_eq("R3", "fetch_kind", int'(fetch_kind), 2);
        rst_n = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        check_eq("R1", "slot_num", int'(slot_num), 1);

        // Table walk over frame 0
        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VEC[i][3:0]);
            wait_to(int'(VEC[i][25:17]), int'(VEC[i][16:10]));
            check_eq(rq, "owner",       int'(owner),       int'(VEC[i][9:8]));
            check_eq(rq, "fetch_kind",  int'(fetch_kind),  int'(VEC[i][7:6]));
            check_eq(rq, "fetch_right", int'(fetch_right), int'(VEC[i][5]));
            check_eq(rq, "cpu_rdy",     int'(cpu_rdy),     int'(VEC[i][4]));
        end
        mon_en = 1'b0;
        check_eq("R12", "longest stall", max_run, 4);

        // R8/R9: early forced refresh on a blank line
        wait_to(260, 10);
        chk_slot("R8", 0, 1);
        cpu_wr = 1'b1; cpu_addr = FADDR;
        wait_to(260, 11);
        cpu_wr = 1'b0;
        chk_slot("R8", 3, 0);
        wait_to(260, 14); chk_slot("R8", 3, 0);
        wait_to(260, 15); chk_slot("R8", 0, 1);
        wait_to(260, 120); chk_slot("R9", 0, 1);
        wait_to(260, 123); chk_slot("R9", 0, 1);
        wait_to(261, 120); chk_slot("R9", 3, 0);

        // R10: late forced refresh crossing the line end
        wait_to(262, 120); chk_slot("R10", 3, 0);
        wait_to(262, 124);
        cpu_wr = 1'b1; cpu_addr = FADDR;
        wait_to(262, 125);
        cpu_wr = 1'b0;
        chk_slot("R10", 3, 0);
        wait_to(263, 0); chk_slot("R10", 3, 0);
        wait_to(263, 2); chk_slot("R10", 3, 0);
        wait_to(263, 3); chk_slot("R10", 0, 1);
        wait_to(263, 120); chk_slot("R10", 0, 1);
        wait_to(264, 120); chk_slot("R10", 3, 0);

        // R11: write to another address
        wait_to(265, 10);
        cpu_wr = 1'b1; cpu_addr = FADDR ^ 16'h0001;
        wait_to(265, 11);
        cpu_wr = 1'b0;
        chk_slot("R11", 0, 1);
        wait_to(265, 120); chk_slot("R11", 3, 0);

        // R11: matching write in a slot the CPU does not own (frame 1)
        wait_to(17, 0);
        chk_slot("R11", 1, 0);
        cpu_wr = 1'b1; cpu_addr = FADDR;
        wait_to(17, 1);
        cpu_wr = 1'b0;
        chk_slot("R11", 0, 1);
        wait_to(17, 2); chk_slot("R11", 1, 0);
        wait_to(17, 120); chk_slot("R11", 3, 0);

        // R8/R9: forced refresh on a half-bad line skips text fetches
        wait_to(23, 3);
        chk_slot("R8", 0, 1);
        cpu_wr = 1'b1; cpu_addr = FADDR;
        wait_to(23, 4);
        cpu_wr = 1'b0;
        chk_slot("R8", 1, 0);
        check_eq("R8", "fetch_kind", int'(fetch_kind), 2);
        wait_to(23, 5); check_eq("R8", "fetch_kind", int'(fetch_kind), 1);
        wait_to(23, 7);  chk_slot("R8", 3, 0);
        wait_to(23, 11); chk_slot("R8", 3, 0);
        wait_to(23, 19); chk_slot("R8", 3, 0);
        wait_to(23, 23); chk_slot("R8", 0, 1);
        wait_to(23, 120); chk_slot("R9", 0, 1);

        // R7: display disabled on an active line
        wait_to(29, 125);
        disp_en = 1'b0;
        wait_to(30, 0);   chk_slot("R7", 0, 1);
        wait_to(30, 80);  chk_slot("R7", 0, 1);
        wait_to(30, 120); chk_slot("R7", 3, 0);

        finish_run();
    end

endmodule